// File: doc/BRIEF.md
# Imperceptible Frequency/Phase Pattern Block Blender

This block hides spread data inside a live video stream. The picture is cut into square pixel blocks, and each block carries one data symbol. The symbol is drawn as a horizontal sinusoidal pattern: its frequency index sets how many periods span the block width, and in hybrid mode one extra bit shifts the pattern by half a period. The pattern is then mixed into the video pixels of that block with a small fixed-point blending factor.

Pixels arrive in raster order together with their coordinates. A symbol is taken from a valid/ready source at the top-left pixel of each block. It is held in a per-block-column store, so later lines of the same block reuse it. If no symbol is offered at that pixel, the whole block leaves the block as unmodified video. The same code value is applied to every colour channel. Mode, block size, frequency count and alpha are quasi-static settings that are changed only between frames.

Top module: `fsk_block_blender`

## Requirements
- R1: `bsize` selects the block edge: 0 gives 16, 1 gives 32, and 2 or 3 give 64 pixels. `sym_ready` is high exactly when `pix_valid` is high and both `pix_x` and `pix_y` are multiples of the block edge. A symbol is consumed only on such a cycle with `sym_valid` high.
- R2: With `mode`=0 (4-bit symbols), `sym_data[3:0]` is the frequency index, `sym_data[4]` is ignored and the phase is 0.
- R3: With `mode`=1 (5-bit hybrid symbols), `sym_data[4]` selects phase 1. Phase 1 adds 32 to the sine address, which is a 180 degree shift, and the frequency still comes from `sym_data[3:0]`.
- R4: The code value of a pixel is 128 + s(a), where s(a) = round(127*sin(2*pi*a/64)). The address is a = ((xo*f) << (6 - log2 edge) + 32*phase) mod 64, with xo the column offset inside the block and f the effective frequency index.
- R5: `nfreq_log2` = n limits the number of frequencies in use to 2^n, with values above 4 treated as 4. The effective frequency is f = `sym_data[3:0]` AND (2^n - 1).
- R6: For a block that holds a symbol, each 8-bit channel of the output is (A*v + (256-A)*c + 128) >> 8. Here v is the video channel, c is the code value and A is the effective alpha, so A/256 is the video weight.
- R7: `alpha` is an unsigned fraction of 256 that is clamped to at most 77 (about 0.3). Any larger value acts as 77.
- R8: A block whose top-left pixel saw no `sym_valid` outputs every one of its pixels equal to the input video.
- R9: A consumed symbol applies to every pixel of its block on all the block's lines, even though the lines of other blocks come in between.
- R10: Each valid input pixel appears on `pix_out` with `out_valid` high exactly 3 clock cycles after it is sampled, in input order, and `out_valid` is low otherwise. Reset clears `out_valid` and `pix_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Input pixel present this cycle |
| pix_x | input | COORD_W | Pixel column |
| pix_y | input | COORD_W | Pixel line |
| pix_in | input | 8*CH | Video pixel, channel 0 in the low byte |
| sym_valid | input | 1 | Symbol offered |
| sym_data | input | 5 | Symbol: bit 4 phase (hybrid), bits 3:0 frequency |
| sym_ready | output | 1 | Symbol accepted this cycle (block top-left pixel) |
| mode | input | 1 | 0: 4-bit frequency-only, 1: 5-bit frequency plus phase |
| bsize | input | 2 | Block edge select |
| nfreq_log2 | input | 3 | log2 of the number of frequencies in use |
| alpha | input | 8 | Video weight in 1/256 units |
| out_valid | output | 1 | Output pixel present |
| pix_out | output | 8*CH | Blended pixel |

## Verification
`sym_ready` is combinational, so the bench checks it one nanosecond after it drives each pixel. The pixel result is due three rising edges after the edge that samples the input. The bench stamps each expected value with the edge count at the time it is driven. Its monitor, on the falling edge, requires the matching output to appear exactly when that count has advanced by three. Idle bubbles are inserted so that a late or early pixel shows up as a count mismatch, not as a wrong value.

// File: rtl/fsk_blend_pkg.sv
package fsk_blend_pkg;
  localparam int MIN_LG  = 4;   // smallest block edge is 2**4
  localparam int MAX_LG  = 6;   // largest block edge is 2**6
  localparam int SINE_AW = 6;   // sine table address width
  localparam int SYM_W   = 5;
  localparam int FREQ_W  = 4;

  typedef struct packed {
    logic              used;
    logic              phase;
    logic [FREQ_W-1:0] freq;
  } blk_sym_t;

  localparam int ENT_W = $bits(blk_sym_t);
endpackage

// File: rtl/sym_column_store.sv
module sym_column_store #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first synchronous port pair, block-RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/code_sine_rom.sv
module code_sine_rom #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  localparam int N    = 1 << AW;
  localparam int HALF = N / 2;
  localparam int QTR  = N / 4;

  // quarter-wave amplitudes for a 64-point period, scaled to 127
  function automatic logic [6:0] qamp(input int k);
    case (k)
      0: qamp = 7'd0;    1: qamp = 7'd12;   2: qamp = 7'd25;   3: qamp = 7'd37;
      4: qamp = 7'd49;   5: qamp = 7'd60;   6: qamp = 7'd71;   7: qamp = 7'd81;
      8: qamp = 7'd90;   9: qamp = 7'd98;  10: qamp = 7'd106; 11: qamp = 7'd112;
     12: qamp = 7'd117; 13: qamp = 7'd122; 14: qamp = 7'd125; 15: qamp = 7'd126;
      default: qamp = 7'd127;
    endcase
  endfunction

  function automatic logic [7:0] wave(input logic [AW-1:0] a);
    int         ai;
    logic [6:0] amp;
    logic       neg;
    ai = int'(a);
    if (ai <= QTR) begin
      amp = qamp(ai);          neg = 1'b0;
    end else if (ai < HALF) begin
      amp = qamp(HALF - ai);   neg = 1'b0;
    end else if (ai <= HALF + QTR) begin
      amp = qamp(ai - HALF);   neg = 1'b1;
    end else begin
      amp = qamp(N - ai);      neg = 1'b1;
    end
    wave = neg ? 8'(8'd128 - {1'b0, amp}) : 8'(8'd128 + {1'b0, amp});
  endfunction

  always_ff @(posedge clk) q <= wave(addr);
endmodule

// File: rtl/pix_blend.sv
module pix_blend #(
  parameter int CH        = 3,
  parameter int ALPHA_MAX = 77
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_use,
  input  logic [7:0]    in_code,
  input  logic [CH*8-1:0] in_pix,
  input  logic [7:0]    alpha,
  output logic          out_valid,
  output logic [CH*8-1:0] out_pix
);
  localparam logic [7:0] AMAX = 8'(ALPHA_MAX);

  logic [7:0]      a_eff;
  logic [8:0]      a_inv;
  logic [CH*8-1:0] mix;

  assign a_eff = (alpha > AMAX) ? AMAX : alpha;
  assign a_inv = 9'd256 - {1'b0, a_eff};

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [9:0] res;
    assign res = 10'(({10'd0, a_eff} * {10'd0, in_pix[c*8 +: 8]} +
                      {9'd0, a_inv} * {10'd0, in_code} + 18'd128) >> 8);
    assign mix[c*8 +: 8] = (res > 10'd255) ? 8'hFF : res[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= in_use ? mix : in_pix;
    end
  end
endmodule

// File: rtl/fsk_block_blender.sv
module fsk_block_blender
  import fsk_blend_pkg::*;
#(
  parameter int COORD_W   = 11,
  parameter int CH        = 3,
  parameter int ALPHA_MAX = 77
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_valid,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [CH*8-1:0]    pix_in,
  input  logic               sym_valid,
  input  logic [SYM_W-1:0]   sym_data,
  output logic               sym_ready,
  input  logic               mode,
  input  logic [1:0]         bsize,
  input  logic [2:0]         nfreq_log2,
  input  logic [7:0]         alpha,
  output logic               out_valid,
  output logic [CH*8-1:0]    pix_out
);
  localparam int COL_W = COORD_W - MIN_LG;
  localparam int PIX_W = CH * 8;

  // ---------------- stage 0: block decode and symbol capture
  logic [2:0]          lg0;
  logic [COORD_W-1:0]  mask_w;
  logic                blk_start;
  logic [COL_W-1:0]    col0;
  logic [MAX_LG-1:0]   xoff0;
  logic [2:0]          nf;
  logic [FREQ_W-1:0]   fmask;
  blk_sym_t            new_ent;

  always_comb begin
    case (bsize)
      2'd0:    lg0 = 3'(MIN_LG);
      2'd1:    lg0 = 3'(MIN_LG + 1);
      default: lg0 = 3'(MAX_LG);
    endcase
  end

  assign mask_w    = ({{(COORD_W-1){1'b0}}, 1'b1} << lg0) - {{(COORD_W-1){1'b0}}, 1'b1};
  assign blk_start = pix_valid && ((pix_x & mask_w) == '0) && ((pix_y & mask_w) == '0);
  assign col0      = COL_W'(pix_x >> lg0);
  assign xoff0     = pix_x[MAX_LG-1:0] & mask_w[MAX_LG-1:0];
  assign sym_ready = blk_start;

  assign nf    = (nfreq_log2 > 3'd4) ? 3'd4 : nfreq_log2;
  assign fmask = 4'((5'd1 << nf) - 5'd1);

  always_comb begin
    new_ent.used  = sym_valid;
    new_ent.phase = mode & sym_data[FREQ_W];
    new_ent.freq  = sym_data[FREQ_W-1:0] & fmask;
  end

  logic [ENT_W-1:0] rd_ent;

  sym_column_store #(.ADDR_W(COL_W), .DATA_W(ENT_W)) store_i (
    .clk     (clk),
    .wr_en   (blk_start),
    .wr_addr (col0),
    .wr_data (new_ent),
    .rd_addr (col0),
    .rd_data (rd_ent)
  );

  // ---------------- stage 1 registers
  logic              s1_valid;
  logic              s1_start;
  blk_sym_t          s1_new;
  logic [MAX_LG-1:0] s1_xoff;
  logic [2:0]        s1_lg;
  logic [PIX_W-1:0]  s1_pix;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_start <= 1'b0;
    end else begin
      s1_valid <= pix_valid;
      s1_start <= blk_start;
    end
    s1_new  <= new_ent;
    s1_xoff <= xoff0;
    s1_lg   <= lg0;
    s1_pix  <= pix_in;
  end

  // ---------------- stage 1 combinational: pattern address
  blk_sym_t           ent;
  logic [SINE_AW-1:0] prod;
  logic [2:0]         sh;
  logic [SINE_AW-1:0] sine_addr;

  assign ent       = s1_start ? s1_new : blk_sym_t'(rd_ent);
  assign prod      = SINE_AW'(s1_xoff * {2'b00, ent.freq});
  assign sh        = 3'(MAX_LG) - s1_lg;
  assign sine_addr = SINE_AW'(prod << sh) + {ent.phase, {(SINE_AW-1){1'b0}}};

  logic [7:0] s2_code;

  code_sine_rom #(.AW(SINE_AW)) rom_i (
    .clk  (clk),
    .addr (sine_addr),
    .q    (s2_code)
  );

  // ---------------- stage 2 registers
  logic             s2_valid;
  logic             s2_use;
  logic [PIX_W-1:0] s2_pix;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_use   <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      s2_use   <= s1_valid & ent.used;
    end
    s2_pix <= s1_pix;
  end

  // ---------------- stage 3: blend, registered output
  pix_blend #(.CH(CH), .ALPHA_MAX(ALPHA_MAX)) blend_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s2_valid),
    .in_use    (s2_use),
    .in_code   (s2_code),
    .in_pix    (s2_pix),
    .alpha     (alpha),
    .out_valid (out_valid),
    .out_pix   (pix_out)
  );
endmodule

// File: rtl/fsk_block_blender_chk.sv
module fsk_block_blender_chk #(
  parameter int COORD_W = 11,
  parameter int CH      = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               pix_valid,
  input logic [COORD_W-1:0] pix_x,
  input logic [COORD_W-1:0] pix_y,
  input logic               sym_ready,
  input logic [7:0]         alpha,
  input logic               out_valid,
  input logic [CH*8-1:0]    pix_out,
  input logic               s2_valid,
  input logic               s2_use,
  input logic [CH*8-1:0]    s2_pix,
  input logic [7:0]         s2_code
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_READY_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    sym_ready |-> (pix_valid && pix_x[3:0] == 4'd0 && pix_y[3:0] == 4'd0)); // R1

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(pix_valid, 3))); // R10

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && !s2_use) |=> (out_valid && pix_out == $past(s2_pix))); // R8

  AST_CODE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_use && alpha == 8'd0) |=> (pix_out == {CH{$past(s2_code)}})); // R6

  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
    !s2_valid |=> !out_valid); // R10
endmodule

bind fsk_block_blender fsk_block_blender_chk #(.COORD_W(COORD_W), .CH(CH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .pix_valid (pix_valid),
  .pix_x     (pix_x),
  .pix_y     (pix_y),
  .sym_ready (sym_ready),
  .alpha     (alpha),
  .out_valid (out_valid),
  .pix_out   (pix_out),
  .s2_valid  (s2_valid),
  .s2_use    (s2_use),
  .s2_pix    (s2_pix),
  .s2_code   (s2_code)
);

// File: tb/fsk_block_blender_tb.sv
`timescale 1ns/1ps
module fsk_block_blender_tb_top;
  localparam int COORD_W = 11;
  localparam int CH      = 3;
  localparam int W       = 64;
  localparam int H       = 64;
  localparam int LAT     = 3;

  logic               clk = 1'b0;
  logic               rst;
  logic               pix_valid;
  logic [COORD_W-1:0] pix_x, pix_y;
  logic [CH*8-1:0]    pix_in;
  logic               sym_valid;
  logic [4:0]         sym_data;
  logic               sym_ready;
  logic               mode;
  logic [1:0]         bsize;
  logic [2:0]         nfreq_log2;
  logic [7:0]         alpha;
  logic               out_valid;
  logic [CH*8-1:0]    pix_out;

  always #2.5 clk = ~clk;

  fsk_block_blender #(.COORD_W(COORD_W), .CH(CH)) dut_i (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .pix_in(pix_in), .sym_valid(sym_valid), .sym_data(sym_data), .sym_ready(sym_ready),
    .mode(mode), .bsize(bsize), .nfreq_log2(nfreq_log2), .alpha(alpha),
    .out_valid(out_valid), .pix_out(pix_out)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  string tag;

  logic [CH*8-1:0] exp_q[$];
  int              cyc_q[$];
  string           tag_q[$];

  // per-block symbol record, filled as the bench hands out symbols
  bit       b_used [4][4];
  bit       b_ph   [4][4];
  int       b_f    [4][4];
  int       ksym;
  int       seed;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int bsin(int a);
    real r;
    r = 127.0 * $sin(2.0 * 3.14159265358979 * a / 64.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic logic [CH*8-1:0] video(int x, int y);
    logic [7:0] c0, c1, c2;
    c0 = 8'((x * 5 + y * 3) & 255);
    c1 = 8'((x * y + 7) & 255);
    c2 = 8'((255 - x - 2 * y) & 255);
    return {c2, c1, c0};
  endfunction

  function automatic bit sym_avail(int k);
    return (k % 5) != 3;
  endfunction

  function automatic logic [4:0] sym_val(int k);
    return 5'((k * 11 + seed) % 32);
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  // output monitor: value and exact arrival cycle (R10)
  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected output", 32'(pix_out), 32'h0);
      end else begin
        logic [CH*8-1:0] e;
        int ec;
        string t;
        e = exp_q.pop_front(); ec = cyc_q.pop_front(); t = tag_q.pop_front();
        check(pix_out == e, {t, " pixel value"}, 32'(pix_out), 32'(e));
        check(cyc == ec + LAT, "R10 output cycle", 32'(cyc), 32'(ec + LAT));
      end
    end
  end

  task automatic idle_cycle();
    @(negedge clk);
    pix_valid = 1'b0;
    #1;
    check(sym_ready == 1'b0, "R1 ready while idle", 32'(sym_ready), 32'h0);
  endtask

  task automatic run_frame(input bit md, input int bs_code, input int nfl, input int al, input int sd, input string t);
    int lg, edge_px, nfe, fmask, aeff;
    @(negedge clk);
    pix_valid = 1'b0;
    mode = md; bsize = 2'(bs_code); nfreq_log2 = 3'(nfl); alpha = 8'(al);
    seed = sd; ksym = 0; tag = t;
    lg = (bs_code == 0) ? 4 : (bs_code == 1) ? 5 : 6;
    edge_px = 1 << lg;
    nfe = (nfl > 4) ? 4 : nfl;
    fmask = (1 << nfe) - 1;
    aeff = (al > 77) ? 77 : al;
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        bit st;
        int bx, by, xo, a, code;
        logic [CH*8-1:0] v, e;
        if (x == 7 && (y % 3) == 1) idle_cycle();
        @(negedge clk);
        st = ((x % edge_px) == 0) && ((y % edge_px) == 0);
        bx = x >> lg; by = y >> lg; xo = x % edge_px;
        v = video(x, y);
        pix_valid = 1'b1; pix_x = COORD_W'(x); pix_y = COORD_W'(y); pix_in = v;
        sym_valid = sym_avail(ksym); sym_data = sym_val(ksym);
        if (st) begin
          b_used[by][bx] = sym_avail(ksym);
          b_ph[by][bx]   = md & sym_data[4];
          b_f[by][bx]    = int'(sym_data[3:0]) & fmask;
          ksym++;
        end
        #1;
        check(sym_ready == st, {"R1 ready ", t}, 32'(sym_ready), 32'(st));
        if (b_used[by][bx]) begin
          a = (((xo * b_f[by][bx]) << (6 - lg)) + 32 * b_ph[by][bx]) % 64;
          code = 128 + bsin(a);
          for (int c = 0; c < CH; c++) begin
            int vc;
            vc = int'(v[c*8 +: 8]);
            e[c*8 +: 8] = 8'((aeff * vc + (256 - aeff) * code + 128) >> 8);
          end
        end else begin
          e = v; // R8 untouched block
        end
        exp_q.push_back(e);
        cyc_q.push_back(cyc);
        tag_q.push_back(b_used[by][bx] ? {t, " R4 R6"} : {t, " R8"});
      end
    end
    for (int i = 0; i < 8; i++) idle_cycle();
    check(exp_q.size() == 0, {"R10 drained ", t}, 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    rst = 1'b1; pix_valid = 1'b0; pix_x = '0; pix_y = '0; pix_in = '0;
    sym_valid = 1'b0; sym_data = '0; mode = 1'b0; bsize = 2'd0;
    nfreq_log2 = 3'd4; alpha = 8'd0;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R10 reset out_valid", 32'(out_valid), 32'h0);
    check(pix_out == '0, "R10 reset pix_out", 32'(pix_out), 32'h0);
    check(sym_ready == 1'b0, "R1 reset ready", 32'(sym_ready), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    // R2 R9: 4-bit mode, bit 4 of the symbol must be ignored, 16x16 blocks
    run_frame(1'b0, 0, 4, 40, 3, "R2 R9 fsk16");
    // R3 R5 R7: hybrid, 32x32, 4 frequencies, alpha above the clamp
    run_frame(1'b1, 1, 2, 200, 17, "R3 R5 R7 hyb32");
    // R3 R5: hybrid, 64x64 via code 3, out-of-range frequency count, alpha 0
    run_frame(1'b1, 3, 7, 0, 9, "R3 R5 hyb64");
    // R5 R6: single frequency gives a flat mid-level code, alpha at the limit
    run_frame(1'b0, 2, 0, 77, 5, "R5 R6 f0");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule